// File: doc/BRIEF.md
# Exception-Bit Conditional Select Unit

This unit executes a family of four conditional-select operations. Each operation writes one of two candidate values to the destination register RT, choosing by the state of a single bit in a sixteen-bit extended exception register. That register stands for architectural exception bits 32 through 47. A four-bit index picks the bit, and index `i` stands for exception bit `32+i`.

Each candidate is, independently, either a 64-bit register value or a five-bit signed immediate that is sign-extended to 64 bits. A two-bit variant code sets which of the two is which. The operand values arrive already read, and the result is returned one clock after the request. The exception register lives in this unit. Other units, such as a pointer-integrity checker, set or clear its bits one at a time through a write port. When a write and a select touch the same bit in the same cycle, the select sees the written value.

When the record flag is set, the unit also returns a three-bit condition field that classifies the signed result.

Top module: `xsel_unit`

## Requirements
- R1: After reset, `excBits` is all zeros, `rspValid` and `condValid` are 0, and `result` and `cond` are 0.
- R2: A request taken with `reqValid` high at a clock edge produces `rspValid` high and the new `result` right after the next edge. `rspValid` is low in every other cycle.
- R3: The result equals the if-on operand when exception bit `32+bitIdx` (`excBits[bitIdx]`) is 1, and the if-off operand when that bit is 0.
- R4: `opSel` picks the operand forms as (if-on, if-off): 2'b00 immediate/immediate, 2'b01 immediate/register, 2'b10 register/immediate, 2'b11 register/register. The if-on pair is `immA`/`regA` and the if-off pair is `immB`/`regB`.
- R5: Immediates are 5-bit two's complement values in the range −16 to +15, sign-extended to 64 bits. An immediate of 0 gives an all-zero result when selected.
- R6: A write with `excWrEn` high sets `excBits[excWrIdx]` to `excWrVal` at the clock edge. All other bits are unchanged. Without a write, `excBits` holds its value.
- R7: When a write and a select occur in the same cycle, the select uses the exception register value after that write.
- R8: When `recordEn` is 1 on a request, `condValid` is 1 with the response and `cond` = {lt, gt, eq} (bit 2 = result < 0, bit 1 = result > 0, bit 0 = result == 0, signed). When `recordEn` is 0, `condValid` is 0.
- R9: With no request, `result` holds its last value. Operand inputs that the variant does not use have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Select request this cycle |
| opSel | input | 2 | Variant code (operand forms) |
| immA | input | 5 | If-on immediate |
| immB | input | 5 | If-off immediate |
| regA | input | 64 | If-on register value |
| regB | input | 64 | If-off register value |
| bitIdx | input | 4 | Exception bit index (bit 32+index) |
| recordEn | input | 1 | Request condition field |
| excWrEn | input | 1 | Exception bit write strobe |
| excWrIdx | input | 4 | Exception bit to write |
| excWrVal | input | 1 | Value written |
| rspValid | output | 1 | Result valid |
| result | output | 64 | Selected value for RT |
| condValid | output | 1 | Condition field valid |
| cond | output | 3 | {lt, gt, eq} of result |
| excBits | output | 16 | Exception bits 32..47 |

## Verification
A bit write and a select that tests the same bit can fall in the same cycle. The bench provokes this by raising `excWrEn` on the bit that the select indexes, in the same cycle as the request. It flips the bit against its stored state in both directions. The scoreboard's model applies the write before it evaluates the selection, so a response based on the stale bit shows up as a mismatch on `result`. The next read of `excBits` then confirms that the write also landed.

// File: rtl/xsel_pkg.sv
package xsel_pkg;
  localparam int DATA_W = 64;
  localparam int IMM_W  = 5;
  localparam int XBITS  = 16;
  localparam int OP_W   = 2;

  typedef enum logic [OP_W-1:0] {
    VAR_II = 2'b00,
    VAR_IR = 2'b01,
    VAR_RI = 2'b10,
    VAR_RR = 2'b11
  } variant_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;
    logic aImm;
    logic bImm;
    logic rec;
  } strobes_t;
endpackage

// File: rtl/xsel_ctrl.sv
module xsel_ctrl
  import xsel_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic           reqValid,
  input  logic [OPW-1:0] opSel,
  input  logic           recordEn,
  output strobes_t       stb
);
  always_comb begin
    stb       = '0;
    stb.issue = reqValid;
    stb.rec   = reqValid & recordEn;
    unique case (variant_e'(opSel))
      VAR_II: begin stb.aImm = 1'b1; stb.bImm = 1'b1; end
      VAR_IR: begin stb.aImm = 1'b1; stb.bImm = 1'b0; end
      VAR_RI: begin stb.aImm = 1'b0; stb.bImm = 1'b1; end
      default: begin stb.aImm = 1'b0; stb.bImm = 1'b0; end
    endcase
  end
endmodule

// File: rtl/xsel_dpath.sv
module xsel_dpath
  import xsel_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IMM_W,
  parameter int NB = XBITS,
  localparam int XW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  strobes_t      stb,
  input  logic [IW-1:0] immA,
  input  logic [IW-1:0] immB,
  input  logic [DW-1:0] regA,
  input  logic [DW-1:0] regB,
  input  logic [XW-1:0] bitIdx,
  input  logic          excWrEn,
  input  logic [XW-1:0] excWrIdx,
  input  logic          excWrVal,
  output logic          rspValid,
  output logic [DW-1:0] result,
  output logic          condValid,
  output logic [2:0]    cond,
  output logic [NB-1:0] excBits
);
  logic [NB-1:0] excQ, excNext;
  logic [DW-1:0] opA, opB, chosen;
  logic          testBit, isNeg, isZero;

  // per-bit write decode; excNext doubles as the write-through bypass
  for (genvar i = 0; i < NB; i++) begin : g_bit
    always_comb begin
      excNext[i] = excQ[i];
      if (excWrEn && (excWrIdx == XW'(i))) excNext[i] = excWrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) excQ <= '0;
    else     excQ <= excNext;
  end

  assign testBit = excNext[bitIdx];
  assign opA     = stb.aImm ? {{(DW-IW){immA[IW-1]}}, immA} : regA;
  assign opB     = stb.bImm ? {{(DW-IW){immB[IW-1]}}, immB} : regB;
  assign chosen  = testBit ? opA : opB;
  assign isNeg   = chosen[DW-1];
  assign isZero  = (chosen == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid  <= 1'b0;
      condValid <= 1'b0;
      result    <= '0;
      cond      <= '0;
    end else begin
      rspValid  <= stb.issue;
      condValid <= stb.rec;
      if (stb.issue) begin
        result <= chosen;
        cond   <= stb.rec ? {isNeg, ~isNeg & ~isZero, isZero} : 3'b000;
      end
    end
  end

  assign excBits = excQ;
endmodule

// File: rtl/xsel_unit.sv
module xsel_unit
  import xsel_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IMM_W,
  parameter int NB = XBITS,
  localparam int XW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reqValid,
  input  logic [OP_W-1:0] opSel,
  input  logic [IW-1:0]   immA,
  input  logic [IW-1:0]   immB,
  input  logic [DW-1:0]   regA,
  input  logic [DW-1:0]   regB,
  input  logic [XW-1:0]   bitIdx,
  input  logic            recordEn,
  input  logic            excWrEn,
  input  logic [XW-1:0]   excWrIdx,
  input  logic            excWrVal,
  output logic            rspValid,
  output logic [DW-1:0]   result,
  output logic            condValid,
  output logic [2:0]      cond,
  output logic [NB-1:0]   excBits
);
  strobes_t stb;

  xsel_ctrl #(.OPW(OP_W)) ctrl (
    .reqValid(reqValid), .opSel(opSel), .recordEn(recordEn), .stb(stb)
  );

  xsel_dpath #(.DW(DW), .IW(IW), .NB(NB)) dpath (
    .clk(clk), .rst(rst), .stb(stb), .immA(immA), .immB(immB),
    .regA(regA), .regB(regB), .bitIdx(bitIdx), .excWrEn(excWrEn),
    .excWrIdx(excWrIdx), .excWrVal(excWrVal), .rspValid(rspValid),
    .result(result), .condValid(condValid), .cond(cond), .excBits(excBits)
  );
endmodule

// File: rtl/xsel_unit_chk.sv
module xsel_unit_chk #(
  parameter int DW = 64,
  parameter int NB = 16,
  localparam int XW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst,
  input logic          reqValid,
  input logic [1:0]    opSel,
  input logic [DW-1:0] regA,
  input logic [DW-1:0] regB,
  input logic [XW-1:0] bitIdx,
  input logic          excWrEn,
  input logic [XW-1:0] excWrIdx,
  input logic          excWrVal,
  input logic          rspValid,
  input logic [DW-1:0] result,
  input logic          condValid,
  input logic [2:0]    cond,
  input logic [NB-1:0] excBits
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);
  // R3
  rr_select_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && opSel == 2'b11 && !excWrEn) |=>
      result == ($past(excBits[bitIdx]) ? $past(regA) : $past(regB)));
  // R6
  bit_write_chk: assert property (@(posedge clk) disable iff (rst)
    excWrEn |=> excBits[$past(excWrIdx)] == $past(excWrVal));
  // R6
  exc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !excWrEn |=> $stable(excBits));
  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && opSel == 2'b11 && excWrEn && excWrIdx == bitIdx) |=>
      result == ($past(excWrVal) ? $past(regA) : $past(regB)));
  // R8
  cond_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    condValid |-> $countones(cond) == 1);
  // R8
  cond_zero_chk: assert property (@(posedge clk) disable iff (rst)
    condValid |-> (cond[0] == (result == '0)));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> $stable(result));
endmodule

bind xsel_unit xsel_unit_chk #(.DW(DW), .NB(NB)) chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .opSel(opSel), .regA(regA),
  .regB(regB), .bitIdx(bitIdx), .excWrEn(excWrEn), .excWrIdx(excWrIdx),
  .excWrVal(excWrVal), .rspValid(rspValid), .result(result),
  .condValid(condValid), .cond(cond), .excBits(excBits)
);

// File: tb/xsel_unit_test.sv
`timescale 1ns/1ps
module xsel_unit_test;
  logic        clk = 0, rst = 1;
  logic        reqValid = 0, recordEn = 0, excWrEn = 0, excWrVal = 0;
  logic [1:0]  opSel = 0;
  logic [4:0]  immA = 0, immB = 0;
  logic [63:0] regA = 0, regB = 0;
  logic [3:0]  bitIdx = 0, excWrIdx = 0;
  logic        rspValid, condValid;
  logic [63:0] result;
  logic [2:0]  cond;
  logic [15:0] excBits;

  always #4 clk = ~clk;

  xsel_unit uut (.*);

  typedef struct {
    logic [63:0] res;
    logic        cv;
    logic [2:0]  cd;
    string       tag;
  } item_t;
  item_t sbq[$];

  int checks = 0, fails = 0;
  logic [15:0] model = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [4:0] v);
    return {{59{v[4]}}, v};
  endfunction

  // driver: called at a negedge, drives one request and pushes its expectation
  task automatic sel(input logic [1:0] op, input logic [4:0] ia, input logic [4:0] ib,
                     input logic [63:0] ra, input logic [63:0] rb, input logic [3:0] idx,
                     input logic rec, input logic wEn, input logic [3:0] wIdx,
                     input logic wVal, input string tag);
    item_t it;
    logic [63:0] a, b;
    reqValid = 1; opSel = op; immA = ia; immB = ib; regA = ra; regB = rb;
    bitIdx = idx; recordEn = rec;
    excWrEn = wEn; excWrIdx = wIdx; excWrVal = wVal;
    if (wEn) model[wIdx] = wVal;
    a = op[1] ? ra : sx(ia);   // R4: 00 II, 01 IR, 10 RI, 11 RR
    b = op[0] ? rb : sx(ib);
    it.res = model[idx] ? a : b;
    it.cv  = rec;
    it.cd  = rec ? {it.res[63], !it.res[63] && it.res != 0, it.res == 0} : 3'b000;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    reqValid = 0; excWrEn = 0; recordEn = 0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic val);
    excWrEn = 1; excWrIdx = idx; excWrVal = val;
    model[idx] = val;
    @(negedge clk);
    excWrEn = 0;
    check(excBits == model, "R6 bit write", 64'(excBits), 64'(model));
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rspValid) begin
      if (sbq.size() == 0) check(0, "R2 unexpected response", 64'(rspValid), 0);
      else begin
        item_t it;
        it = sbq.pop_front();
        check(result == it.res, it.tag, result, it.res);
        if (it.cv) check(condValid && cond == it.cd, {it.tag, " R8 cond"}, 64'({condValid, cond}), 64'({1'b1, it.cd}));
        else       check(!condValid, {it.tag, " R8 no cond"}, 64'(condValid), 0);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 0);
    finishRun();
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check(excBits == 0 && !rspValid && !condValid && result == 0 && cond == 0,
          "R1 reset state", {rspValid, condValid, cond, excBits, result[40:0]}, 0);
    // R6 single-bit writes
    wr(4'd9, 1);
    wr(4'd15, 1);
    wr(4'd0, 1);
    wr(4'd9, 0);
    wr(4'd3, 0);
    // R3/R4 all variants with bit on (15) and off (3)
    sel(2'b00, 5'd7, 5'd2, 64'hDEAD, 64'hBEEF, 4'd15, 0, 0, 0, 0, "R4 II on");
    sel(2'b00, 5'd7, 5'd2, 64'hDEAD, 64'hBEEF, 4'd3, 0, 0, 0, 0, "R4 II off");
    sel(2'b01, 5'd5, 5'd1, 64'h1111, 64'h2222, 4'd15, 0, 0, 0, 0, "R4 IR on");
    sel(2'b01, 5'd5, 5'd1, 64'h1111, 64'h2222, 4'd3, 0, 0, 0, 0, "R4 IR off");
    sel(2'b10, 5'd5, 5'd1, 64'h3333, 64'h4444, 4'd15, 0, 0, 0, 0, "R4 RI on");
    sel(2'b10, 5'd5, 5'd1, 64'h3333, 64'h4444, 4'd3, 0, 0, 0, 0, "R4 RI off");
    sel(2'b11, 5'd5, 5'd1, 64'hA5A5_0000_0000_5A5A, 64'h0123_4567_89AB_CDEF, 4'd15, 0, 0, 0, 0, "R3 RR on");
    sel(2'b11, 5'd5, 5'd1, 64'hA5A5_0000_0000_5A5A, 64'h0123_4567_89AB_CDEF, 4'd3, 0, 0, 0, 0, "R3 RR off");
    // R3: index 0 and index 9 (exception bit 41)
    sel(2'b11, 0, 0, 64'h77, 64'h88, 4'd0, 0, 0, 0, 0, "R3 index 0");
    wr(4'd9, 1);
    sel(2'b10, 0, 5'd0, 64'hCAFE_F00D, 64'h0, 4'd9, 0, 0, 0, 0, "R3 bit41 on");
    wr(4'd9, 0);
    sel(2'b10, 0, 5'd0, 64'hCAFE_F00D, 64'h0, 4'd9, 0, 0, 0, 0, "R5 zero imm");
    // R5 extremes
    sel(2'b00, 5'b10000, 5'b01111, 0, 0, 4'd15, 1, 0, 0, 0, "R5 imm -16");
    sel(2'b00, 5'b10000, 5'b01111, 0, 0, 4'd3, 1, 0, 0, 0, "R5 imm +15");
    sel(2'b01, 5'b11111, 5'd0, 0, 64'h5, 4'd15, 0, 0, 0, 0, "R5 imm -1");
    // R7 bypass both directions
    sel(2'b11, 0, 0, 64'hAAAA, 64'hBBBB, 4'd6, 0, 1, 4'd6, 1, "R7 bypass set");
    check(excBits == model, "R7 write landed", 64'(excBits), 64'(model));
    sel(2'b11, 0, 0, 64'hAAAA, 64'hBBBB, 4'd6, 0, 1, 4'd6, 0, "R7 bypass clear");
    check(excBits == model, "R7 write landed", 64'(excBits), 64'(model));
    sel(2'b11, 0, 0, 64'h1, 64'h2, 4'd15, 0, 1, 4'd2, 1, "R7 other bit write");
    // R8 record on negative, positive, zero results
    sel(2'b11, 0, 0, 64'h8000_0000_0000_0001, 0, 4'd15, 1, 0, 0, 0, "R8 negative");
    sel(2'b11, 0, 0, 64'h42, 0, 4'd15, 1, 0, 0, 0, "R8 positive");
    sel(2'b11, 0, 0, 64'h42, 0, 4'd3, 1, 0, 0, 0, "R8 zero");
    sel(2'b00, 5'd1, 0, 0, 0, 4'd15, 0, 0, 0, 0, "R8 record off");
    // R9: idle cycles with changed inputs leave result alone
    @(negedge clk);
    held = result;
    regA = 64'hFFFF; regB = 64'hEEEE; immA = 5'd9; bitIdx = 4'd3;
    repeat (3) @(negedge clk);
    check(result == held && !rspValid, "R9 hold with no request", result, held);
    // R9: unused register inputs ignored in II
    sel(2'b00, 5'd3, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 4'd15, 0, 0, 0, 0, "R9 unused regs");
    @(negedge clk);
    check(sbq.size() == 0, "R2 responses drained", sbq.size(), 0);
    finishRun();
  end
endmodule